// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic and logic engine of an 8-bit accumulator machine. On each accepted request it combines the accumulator operand `a_i` with a second operand. That operand is a memory byte, or the index byte X used as a general register, presented on `m_i`. The block returns a new accumulator value and updates five condition flags. These flags are signed overflow, half carry, negative, zero and carry. Together they let a branch unit decide on signed, unsigned and packed-decimal results. A decimal-adjust operation uses the half carry and carry to correct the sum of two packed BCD bytes.

Two operations take several cycles. An 8×8 multiply of `a_i` by `x_i` returns a 16-bit product split across the accumulator and X results. A 16÷8 divide takes `{h_i, a_i}` as the dividend and `x_i` as the divisor, and returns quotient and remainder. While either is running, `busy_o` is high and new requests are dropped. Every operation ends with a one-cycle `done_o` pulse. Results and flags become visible in that same cycle. Flags are held inside the block, and ADC and SBC use the stored carry.

Top module: `alu8_cc`

## Requirements
- R1: After reset, `res_o`, `aux_o` and `flags_o` are zero, and `done_o` and `busy_o` are low. The flag layout is `flags_o[4]`=V, `[3]`=H, `[2]`=N, `[1]`=Z, `[0]`=C.
- R2: ADD (op 0) gives `a_i+m_i`, and ADC (op 1) also adds the stored C. C is the carry out of bit 7 and H is the carry out of bit 3. V is set when both operands have the same sign and the result sign differs.
- R3: SUB (op 2) gives `a_i-m_i` and SBC (op 3) also subtracts the stored C. C is set as a borrow, meaning unsigned `a_i` was below the subtrahend. V is set when the operand signs differ and the result sign differs from `a_i`. H is left unchanged.
- R4: CMP (op 4) sets V, N, Z and C exactly as SUB does. `res_o` becomes `a_i` unchanged.
- R5: AND (op 5), OR (op 6) and EOR (op 7) produce the bitwise result and clear V. They leave H and C unchanged.
- R6: Every operation that updates N and Z sets N to bit 7 of the 8-bit result and Z when that result is zero.
- R7: DAA (op 8) adds 0x06 when H is set or the low nibble of `a_i` is above 9. It adds 0x60 when C is set or `a_i` is above 0x99. C becomes set exactly when 0x60 was added. V and H are unchanged.
- R8: Every operation other than a started multiply or a valid divide, including op codes 11 to 15, raises `done_o` for one cycle, one clock after it is accepted. Op codes 11 to 15 copy `a_i` to `res_o` and leave the flags unchanged.
- R9: MUL (op 9) returns `a_i*x_i`, with the high byte on `aux_o` and the low byte on `res_o`. It clears H and C and leaves V, N and Z unchanged. `done_o` rises 5 clocks after acceptance.
- R10: DIV (op 10), when `x_i` is nonzero and `h_i < x_i`, returns the quotient of `{h_i,a_i}/x_i` on `res_o` and the remainder on `aux_o`. It clears C, sets Z exactly when the quotient is zero, and leaves V, H and N unchanged. `done_o` rises 9 clocks after acceptance.
- R11: DIV with `x_i` zero or `h_i >= x_i` sets C and returns `a_i` on `res_o` and `h_i` on `aux_o`. It leaves V, H, N and Z unchanged and signals `done_o` one clock later.
- R12: While `busy_o` is high, `start_i` is ignored. No extra `done_o` pulse appears, and results and flags change only when the running operation finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, accepted when not busy |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | Accumulator operand, low dividend byte |
| m_i | input | 8 | Second operand (memory or X) |
| x_i | input | 8 | Multiplier / divisor |
| h_i | input | 8 | High dividend byte |
| res_o | output | 8 | New accumulator value |
| aux_o | output | 8 | Product high byte or remainder |
| flags_o | output | 5 | V,H,N,Z,C |
| busy_o | output | 1 | Multi-cycle operation running |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The divider's remainder bound depends on two things. First, the divider must only ever be started with a high dividend byte below the divisor. Second, the top must screen out every other request as an error, so the bench drives both in-range and out-of-range divides, including a zero divisor and `h_i == x_i`. The busy-hold property depends on requests that arrive while busy being dropped. The bench drives a request during a multiply on purpose, and holds its operand inputs steady otherwise, one pulse per request on the falling edge.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBC = 4'd3,
    OP_CMP = 4'd4, OP_AND = 4'd5, OP_OR  = 4'd6, OP_EOR = 4'd7,
    OP_DAA = 4'd8, OP_MUL = 4'd9, OP_DIV = 4'd10
  } op_e;

  typedef struct packed {
    logic v;
    logic h;
    logic n;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/alu8_simple.sv
module alu8_simple
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  flags_t       flg_i,
  output logic [W-1:0] res_o,
  output flags_t       flg_o
);
  localparam int HB = W / 2;

  logic         cin;
  logic [W:0]   sum;
  logic [HB:0]  hsum;
  logic [W:0]   dif;
  logic         lo_fix, hi_fix;
  logic [W-1:0] adj;

  assign cin    = (op_i == OP_ADC || op_i == OP_SBC) ? flg_i.c : 1'b0;
  assign sum    = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin};
  assign hsum   = {1'b0, a_i[HB-1:0]} + {1'b0, b_i[HB-1:0]} + {{HB{1'b0}}, cin};
  assign dif    = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin};
  assign lo_fix = flg_i.h || (a_i[HB-1:0] > HB'(9));
  assign hi_fix = flg_i.c || (a_i > W'(8'h99));
  assign adj    = {(hi_fix ? HB'(6) : HB'(0)), (lo_fix ? HB'(6) : HB'(0))};

  always_comb begin
    res_o = a_i;
    flg_o = flg_i;
    unique case (op_i)
      OP_ADD, OP_ADC: begin
        res_o   = sum[W-1:0];
        flg_o.c = sum[W];
        flg_o.h = hsum[HB];
        flg_o.v = (a_i[W-1] == b_i[W-1]) && (sum[W-1] != a_i[W-1]);
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        if (op_i != OP_CMP) res_o = dif[W-1:0];
        flg_o.c = dif[W];
        flg_o.v = (a_i[W-1] != b_i[W-1]) && (dif[W-1] != a_i[W-1]);
      end
      OP_AND: begin res_o = a_i & b_i; flg_o.v = 1'b0; end
      OP_OR:  begin res_o = a_i | b_i; flg_o.v = 1'b0; end
      OP_EOR: begin res_o = a_i ^ b_i; flg_o.v = 1'b0; end
      OP_DAA: begin
        res_o   = a_i + adj;
        flg_o.c = hi_fix;
      end
      default: ;
    endcase
    if (op_i inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP,
                     OP_AND, OP_OR, OP_EOR, OP_DAA}) begin
      flg_o.n = (op_i == OP_CMP) ? dif[W-1] : res_o[W-1];
      flg_o.z = (op_i == OP_CMP) ? (dif[W-1:0] == '0) : (res_o == '0);
    end
  end
endmodule

// File: rtl/alu8_mul.sv
module alu8_mul #(
  parameter int W = 8,
  parameter int R = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic           busy_o,
  output logic           fin_o,
  output logic [2*W-1:0] prod_o
);
  localparam int STEPS = W / R;
  localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic           busy_q;
  logic [CW-1:0]  cnt_q;
  logic [2*W-1:0] acc_q, mc_q, part;
  logic [W-1:0]   mp_q;

  assign part   = mc_q * {{(2*W-R){1'b0}}, mp_q[R-1:0]};
  assign prod_o = acc_q + part;
  assign fin_o  = busy_q && (cnt_q == CW'(STEPS - 1));
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= '0;
      mc_q   <= '0;
      mp_q   <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      acc_q  <= '0;
      mc_q   <= {{W{1'b0}}, a_i};
      mp_q   <= b_i;
    end else if (busy_q) begin
      acc_q <= prod_o;
      mc_q  <= mc_q << R;
      mp_q  <= mp_q >> R;
      cnt_q <= cnt_q + CW'(1);
      if (fin_o) busy_q <= 1'b0;
    end
  end

  p_mul_runs_on_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !fin_o && !start_i |=> busy_q);
  p_mul_stops_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o && !start_i |=> !busy_q);
endmodule

// File: rtl/alu8_div.sv
module alu8_div #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] dvs_i,
  output logic         busy_o,
  output logic         fin_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int CW = $clog2(W);

  logic         busy_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0] rem_q, quo_q, dvs_q;
  logic [W:0]   trial, diff;
  logic         ge;

  assign trial  = {rem_q, quo_q[W-1]};
  assign diff   = trial - {1'b0, dvs_q};
  assign ge     = trial >= {1'b0, dvs_q};
  assign rem_o  = ge ? diff[W-1:0] : trial[W-1:0];
  assign quo_o  = {quo_q[W-2:0], ge};
  assign fin_o  = busy_q && (cnt_q == CW'(W - 1));
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      rem_q  <= hi_i;
      quo_q  <= lo_i;
      dvs_q  <= dvs_i;
    end else if (busy_q) begin
      rem_q <= rem_o;
      quo_q <= quo_o;
      cnt_q <= cnt_q + CW'(1);
      if (fin_o) busy_q <= 1'b0;
    end
  end

  // holds only because the top never starts a divide with hi_i >= dvs_i
  p_rem_below_dvs_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> rem_q < dvs_q);
endmodule

// File: rtl/alu8_cc.sv
module alu8_cc
  import alu8_pkg::*;
#(
  parameter int W      = 8,
  parameter int MUL_R  = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] m_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] h_i,
  output logic [W-1:0] res_o,
  output logic [W-1:0] aux_o,
  output logic [4:0]   flags_o,
  output logic         busy_o,
  output logic         done_o
);
  op_e            op;
  flags_t         flg_q, lu_flg;
  logic [W-1:0]   lu_res, res_q, aux_q, quo, rem;
  logic [2*W-1:0] prod;
  logic           start_ok, div_err, mul_go, div_go, simple_go, done_q;
  logic           mul_busy, mul_fin, div_busy, div_fin;

  assign op        = op_e'(op_i);
  assign busy_o    = mul_busy | div_busy;
  assign start_ok  = start_i & ~busy_o;
  assign div_err   = (x_i == '0) || (h_i >= x_i);
  assign mul_go    = start_ok && (op == OP_MUL);
  assign div_go    = start_ok && (op == OP_DIV) && !div_err;
  assign simple_go = start_ok && !mul_go && !div_go;

  alu8_simple #(.W(W)) u_simple (
    .op_i(op), .a_i(a_i), .b_i(m_i), .flg_i(flg_q),
    .res_o(lu_res), .flg_o(lu_flg)
  );

  alu8_mul #(.W(W), .R(MUL_R)) u_mul (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(mul_go),
    .a_i(a_i), .b_i(x_i),
    .busy_o(mul_busy), .fin_o(mul_fin), .prod_o(prod)
  );

  alu8_div #(.W(W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(div_go),
    .hi_i(h_i), .lo_i(a_i), .dvs_i(x_i),
    .busy_o(div_busy), .fin_o(div_fin), .quo_o(quo), .rem_o(rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      aux_q  <= '0;
      flg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (simple_go) begin
        done_q <= 1'b1;
        if (op == OP_DIV) begin
          res_q   <= a_i;
          aux_q   <= h_i;
          flg_q.c <= 1'b1;
        end else if (op == OP_MUL) begin
          res_q <= res_q;
        end else begin
          res_q <= lu_res;
          flg_q <= lu_flg;
        end
      end else if (mul_fin) begin
        done_q  <= 1'b1;
        res_q   <= prod[W-1:0];
        aux_q   <= prod[2*W-1:W];
        flg_q.h <= 1'b0;
        flg_q.c <= 1'b0;
      end else if (div_fin) begin
        done_q  <= 1'b1;
        res_q   <= quo;
        aux_q   <= rem;
        flg_q.c <= 1'b0;
        flg_q.z <= (quo == '0);
      end
    end
  end

  assign res_o   = res_q;
  assign aux_o   = aux_q;
  assign flags_o = flg_q;
  assign done_o  = done_q;

  p_simple_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    simple_go |=> done_o);
  p_busy_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !mul_fin && !div_fin |=> !done_o && $stable(flags_o) && $stable(res_o));
  p_mul_clears_hc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mul_fin |=> !flags_o[3] && !flags_o[0]);
  p_div_err_keep_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ok && (op == OP_DIV) && div_err |=>
      flags_o[0] && res_o == $past(a_i) && aux_o == $past(h_i));
  p_one_unit_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mul_busy, div_busy}));
endmodule

// File: tb/alu8_cc_test.sv
module alu8_cc_test;
  localparam int MUL_LAT = 5;
  localparam int DIV_LAT = 9;

  logic       clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] a_i = '0, m_i = '0, x_i = '0, h_i = '0;
  logic [7:0] res_o, aux_o;
  logic [4:0] flags_o;
  logic       busy_o, done_o;

  int checks = 0, errors = 0;
  logic [4:0] ef = '0;  // expected flags {V,H,N,Z,C}

  always #2.5 clk_i = ~clk_i;

  alu8_cc uut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // issue one request, return clocks until done_o seen (sampled at negedge)
  task automatic issue(input logic [3:0] op, input logic [7:0] a, m, x, h, output int lat);
    @(negedge clk_i);
    start_i = 1'b1; op_i = op; a_i = a; m_i = m; x_i = x; h_i = h;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 40) begin
      @(negedge clk_i);
      lat++;
    end
  endtask

  function automatic logic [12:0] model(input logic [3:0] op, input logic [7:0] a, m, input logic [4:0] f);
    logic [8:0] s; logic [4:0] hs; logic [7:0] r; logic [4:0] nf; logic ci, lo, hi;
    nf = f; r = a; ci = (op == 1 || op == 3) ? f[0] : 1'b0;
    case (op)
      0, 1: begin
        s = a + m + ci; hs = a[3:0] + m[3:0] + ci; r = s[7:0];
        nf[0] = s[8]; nf[3] = hs[4];
        nf[4] = (a[7] == m[7]) && (r[7] != a[7]);
      end
      2, 3, 4: begin
        s = {1'b0, a} - {1'b0, m} - ci;
        nf[0] = s[8]; nf[4] = (a[7] != m[7]) && (s[7] != a[7]);
        r = (op == 4) ? a : s[7:0];
        nf[2] = s[7]; nf[1] = (s[7:0] == 0);
      end
      5: r = a & m;
      6: r = a | m;
      7: r = a ^ m;
      8: begin
        lo = f[3] || a[3:0] > 9; hi = f[0] || a > 8'h99;
        r = a + (lo ? 8'h06 : 8'h00) + (hi ? 8'h60 : 8'h00);
        nf[0] = hi;
      end
      default: ;
    endcase
    if (op >= 5 && op <= 7) nf[4] = 1'b0;
    if (op <= 3 || (op >= 5 && op <= 8)) begin nf[2] = r[7]; nf[1] = (r == 0); end
    return {nf, r};
  endfunction

  task automatic t_simple(input logic [3:0] op, input logic [7:0] a, m, input string tag);
    int lat; logic [12:0] e;
    e = model(op, a, m, ef);
    issue(op, a, m, 8'h00, 8'h00, lat);
    ef = e[12:8];
    chk(lat == 1, {tag, " R8 latency"}, lat, 1);
    chk(res_o == e[7:0], {tag, " result"}, res_o, e[7:0]);
    chk(flags_o == ef, {tag, " flags R6"}, flags_o, ef);
    @(negedge clk_i);
    chk(!done_o, {tag, " R8 single pulse"}, done_o, 0);
  endtask

  task automatic t_mul(input logic [7:0] a, x);
    int lat; logic [15:0] p;
    p = a * x;
    issue(4'd9, a, 8'h00, x, 8'h00, lat);
    ef[3] = 1'b0; ef[0] = 1'b0;
    chk(lat == MUL_LAT, "R9 mul latency", lat, MUL_LAT);
    chk({aux_o, res_o} == p, "R9 mul product", {aux_o, res_o}, p);
    chk(flags_o == ef, "R9 mul flags", flags_o, ef);
  endtask

  task automatic t_div(input logic [7:0] h, a, x);
    int lat; logic [15:0] d; logic [7:0] q, r;
    d = {h, a}; q = 8'(d / x); r = 8'(d % x);
    issue(4'd10, a, 8'h00, x, h, lat);
    ef[0] = 1'b0; ef[1] = (q == 0);
    chk(lat == DIV_LAT, "R10 div latency", lat, DIV_LAT);
    chk(res_o == q, "R10 quotient", res_o, q);
    chk(aux_o == r, "R10 remainder", aux_o, r);
    chk(flags_o == ef, "R10 div flags", flags_o, ef);
  endtask

  task automatic t_div_err(input logic [7:0] h, a, x);
    int lat;
    issue(4'd10, a, 8'h00, x, h, lat);
    ef[0] = 1'b1;
    chk(lat == 1, "R11 div error latency", lat, 1);
    chk(res_o == a, "R11 A kept", res_o, a);
    chk(aux_o == h, "R11 H kept", aux_o, h);
    chk(flags_o == ef, "R11 flags", flags_o, ef);
  endtask

  task automatic t_busy_ignore();
    int lat;
    @(negedge clk_i);
    start_i = 1'b1; op_i = 4'd9; a_i = 8'h03; x_i = 8'h05;
    @(negedge clk_i);
    op_i = 4'd0; a_i = 8'h01; m_i = 8'h01;  // arrives while busy
    chk(busy_o, "R12 busy during mul", busy_o, 1);
    @(negedge clk_i);
    start_i = 1'b0;
    chk(!done_o, "R12 no done for dropped request", done_o, 0);
    lat = 2;
    while (!done_o && lat < 40) begin @(negedge clk_i); lat++; end
    ef[3] = 1'b0; ef[0] = 1'b0;
    chk(lat == MUL_LAT, "R12 mul latency unaffected", lat, MUL_LAT);
    chk({aux_o, res_o} == 16'd15, "R12 mul result unaffected", {aux_o, res_o}, 15);
    chk(flags_o == ef, "R12 flags", flags_o, ef);
    @(negedge clk_i);
    chk(!done_o, "R12 no late done", done_o, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(res_o == 0 && aux_o == 0, "R1 reset data", {aux_o, res_o}, 0);
    chk(flags_o == 0, "R1 reset flags", flags_o, 0);
    chk(!done_o && !busy_o, "R1 reset strobes", {done_o, busy_o}, 0);
    rst_ni = 1'b1;
    t_simple(4'd0, 8'h7F, 8'h01, "R2 add overflow");
    t_simple(4'd0, 8'hFF, 8'h01, "R2 add carry zero");
    t_simple(4'd1, 8'h10, 8'h20, "R2 adc carry in");
    t_simple(4'd2, 8'h10, 8'h20, "R3 sub borrow");
    t_simple(4'd2, 8'h80, 8'h01, "R3 sub overflow");
    t_simple(4'd3, 8'h50, 8'h10, "R3 sbc");
    t_simple(4'd4, 8'h42, 8'h42, "R4 cmp equal");
    t_simple(4'd4, 8'h01, 8'h02, "R4 cmp less");
    t_simple(4'd5, 8'hF0, 8'h0F, "R5 and");
    t_simple(4'd6, 8'h80, 8'h01, "R5 or");
    t_simple(4'd7, 8'h5A, 8'h5A, "R5 eor");
    t_simple(4'd0, 8'h15, 8'h27, "R7 add bcd");
    t_simple(4'd8, res_o, 8'h00, "R7 daa low fix");
    t_simple(4'd0, 8'h99, 8'h01, "R7 add bcd 99");
    t_simple(4'd8, res_o, 8'h00, "R7 daa wrap");
    t_simple(4'd12, 8'h33, 8'h44, "R8 unused op");
    t_mul(8'hFF, 8'hFF);
    t_mul(8'h0C, 8'h0A);
    t_div(8'h01, 8'hF4, 8'h0A);
    t_div(8'h00, 8'h05, 8'h07);
    t_div_err(8'h12, 8'h34, 8'h00);
    t_div_err(8'h10, 8'h00, 8'h10);
    t_busy_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule